// File: doc/BRIEF.md
# Flash Cycle Sequencer

This block turns a host request for a single flash read or write of one or two bytes into a short, guarded conversation with a flash engine. Each request carries an operation, a byte index, a size and write data. The block first validates the request and forms a 24-bit linear address by adding a configured base. It then prepares the engine: it confirms that the engine's descriptor is valid, clears the sticky error flag and waits for any cycle still running. After that it fires a one-cycle go strobe and polls for completion. Every wait is bounded by a timeout counted in clock cycles.

When a cycle ends with the error flag set, the whole preparation and launch sequence is repeated, up to a bounded number of extra attempts. A failure with the error flag clear ends the transaction at once. The outcome returns on a response channel as a status code together with any read data.

Both host channels are valid/ready:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high only while no transaction is in flight.
- A response stays valid, with unchanged status and data, until the host accepts it with `rsp_ready`.
- The next request is taken only after that acceptance.

The engine-side pins are plain control and status signals.

Top module: `flash_cycle_seq`

## Requirements
- R1: `req_ready` is 1 out of reset and whenever the block is idle, and 0 from the edge that accepts a request until the response is accepted. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_status` and `rsp_rdata` hold their values. `req_ready` and `rsp_valid` are never 1 together.
- R2: A request whose size is not 1 or 2, or whose 32-bit index exceeds 0x00FFFFFF, is answered with status 1 (rejected) and no go strobe.
- R3: At the go strobe, `fl_addr` equals the low 24 bits of the index plus the base parameter, modulo 2^24.
- R4: At the go strobe, `fl_type` is 0 for a read (`req_write`=0) and 2 for a write (`req_write`=1). `fl_bcount` is the size minus one (0 for one byte, 1 for two bytes).
- R5: If `fl_desc_valid` is 0 when a cycle is being prepared, the transaction ends with status 5 (no descriptor) and no go strobe.
- R6: If the engine reports busy while a cycle is being prepared, the block waits and launches once busy drops. If busy lasts the whole timeout, the transaction ends with status 2 (busy) and no go strobe.
- R7: A cycle that reports done with no error ends the transaction with status 0 (success). A cycle that gets no done within the timeout and has no error ends it with status 3 (timeout), after exactly one go strobe.
- R8: A cycle that ends with the error flag set repeats the whole preparation and launch, up to MAX_RETRY (default 10) extra attempts. If every attempt fails, the transaction ends with status 4 (retries exhausted) after MAX_RETRY+1 go strobes. If attempt k is the first to succeed, exactly k+1 go strobes were issued.
- R9: For a successful read, `rsp_rdata` is the engine data's low byte zero-extended for size 1, and its low 16 bits for size 2. In every other case `rsp_rdata` is 0.
- R10: At the go strobe of a write, `fl_wdata` carries the request data for size 2. For size 1 it carries only the low byte, with the upper byte 0.
- R11: `fl_go` is a single-cycle pulse and is never high while `fl_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Byte index into the flash region |
| req_size | input | 2 | Transfer size in bytes (1 or 2 valid) |
| req_wdata | input | 16 | Write data, low byte first |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_status | output | 3 | 0 ok, 1 rejected, 2 busy, 3 timeout, 4 retries exhausted, 5 no descriptor |
| rsp_rdata | output | 16 | Read data on a successful read, else 0 |
| fl_go | output | 1 | One-cycle cycle start strobe |
| fl_type | output | 2 | Cycle type: 0 read, 2 write |
| fl_bcount | output | 1 | Byte count minus one |
| fl_addr | output | 24 | Flash linear address |
| fl_wdata | output | 16 | Data for a write cycle |
| fl_busy | input | 1 | Engine reports a cycle in progress |
| fl_done | input | 1 | Engine pulses at cycle completion |
| fl_err | input | 1 | Engine pulses with done when the cycle failed |
| fl_rdata | input | 16 | Data returned by a read cycle, valid with done |
| fl_desc_valid | input | 1 | Engine descriptor is valid |

## Verification
The assertions take three things for granted about the engine:
- It raises busy only in answer to a go strobe, so busy that was low at preparation stays low at launch.
- It holds `fl_desc_valid` steady for the length of a transaction.
- It pulses `fl_err` only together with `fl_done`.

The bench engine model keeps to these rules. Pre-existing busy is a window that only ever ends. Descriptor, latency and error schedule are fixed before each request is offered and left alone until its response is accepted. Busy holds and cycle latencies are kept well below or far beyond the timeout, so that no check depends on the exact cycle the timeout fires.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    CYC_READ  = 2'd0,
    CYC_RSVD  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_ERASE = 2'd3
  } cyc_type_e;

  typedef enum logic [2:0] {
    RSP_OK        = 3'd0,
    RSP_REJECT    = 3'd1,
    RSP_BUSY      = 3'd2,
    RSP_TIMEOUT   = 3'd3,
    RSP_RETRY_OUT = 3'd4,
    RSP_NO_DESC   = 3'd5
  } rsp_code_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_WAIT_IDLE, S_LAUNCH, S_POLL, S_RESP
  } seq_state_e;
endpackage

// File: rtl/flash_req_check.sv
module flash_req_check #(
  parameter int unsigned IDX_W  = 32,
  parameter int unsigned ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [IDX_W-1:0]  index,
  input  logic [1:0]        size,
  output logic              ok,
  output logic [ADDR_W-1:0] addr
);
  logic idx_ok;

  generate
    if (IDX_W > ADDR_W) begin : g_wide
      assign idx_ok = (index[IDX_W-1:ADDR_W] == '0);
    end else begin : g_narrow
      assign idx_ok = 1'b1;
    end
  endgenerate

  assign ok   = idx_ok && (size == 2'd1 || size == 2'd2);
  assign addr = index[ADDR_W-1:0] + BASE;
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int unsigned LIMIT = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic en,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (en && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = en && (cnt_q == LAST);
endmodule

// File: rtl/flash_hw_status.sv
module flash_hw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic set_err,
  input  logic clr_done,
  input  logic clr_err,
  output logic done,
  output logic err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (set_done) done <= 1'b1;
      else if (clr_done) done <= 1'b0;
      if (set_err) err <= 1'b1;
      else if (clr_err) err <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cycle_seq.sv
module flash_cycle_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned IDX_W      = 32,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 16,
  parameter logic [ADDR_W-1:0] BASE = 24'h010000,
  parameter int unsigned CYC_PER_US = 125,
  parameter int unsigned TIMEOUT_US = 5000,
  parameter int unsigned MAX_RETRY  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fl_go,
  output logic [1:0]        fl_type,
  output logic              fl_bcount,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic              fl_busy,
  input  logic              fl_done,
  input  logic              fl_err,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic              fl_desc_valid
);
  localparam int unsigned LIMIT = CYC_PER_US * TIMEOUT_US;
  localparam int unsigned RW    = $clog2(MAX_RETRY + 1);
  localparam int unsigned BYTE_W = DATA_W / 2;
  localparam logic [RW-1:0] RLAST = RW'(MAX_RETRY);

  seq_state_e        state_q;
  logic              wr_q, two_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdbuf_q, rdata_q;
  logic [2:0]        status_q;
  logic [RW-1:0]     retry_q;

  logic              chk_ok;
  logic [ADDR_W-1:0] chk_addr;
  logic              sts_done, sts_err;
  logic              tmr_start, tmr_en, tmr_exp;
  logic              clr_err, clr_done;

  flash_req_check #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_check (
    .index(req_index), .size(req_size), .ok(chk_ok), .addr(chk_addr)
  );

  flash_seq_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .en(tmr_en), .expired(tmr_exp)
  );

  flash_hw_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set_done(fl_done), .set_err(fl_err),
    .clr_done(clr_done), .clr_err(clr_err),
    .done(sts_done), .err(sts_err)
  );

  // write-one-clear of the sticky error flag during preparation,
  // done flag cleared as the cycle is launched
  assign clr_err   = (state_q == S_PREP) && fl_desc_valid;
  assign clr_done  = (state_q == S_LAUNCH);
  assign tmr_start = (state_q == S_PREP) || (state_q == S_LAUNCH);
  assign tmr_en    = (state_q == S_WAIT_IDLE) || (state_q == S_POLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      wr_q     <= 1'b0;
      two_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdbuf_q  <= '0;
      rdata_q  <= '0;
      status_q <= RSP_OK;
      retry_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          two_q   <= (req_size == 2'd2);
          addr_q  <= chk_addr;
          wdata_q <= (req_size == 2'd2) ? req_wdata
                                        : {{(DATA_W-BYTE_W){1'b0}}, req_wdata[BYTE_W-1:0]};
          rdata_q <= '0;
          retry_q <= '0;
          if (!chk_ok) begin
            status_q <= RSP_REJECT;
            state_q  <= S_RESP;
          end else begin
            state_q  <= S_PREP;
          end
        end
        S_PREP: begin
          if (!fl_desc_valid) begin
            status_q <= RSP_NO_DESC;
            state_q  <= S_RESP;
          end else if (!fl_busy) begin
            state_q  <= S_LAUNCH;
          end else begin
            state_q  <= S_WAIT_IDLE;
          end
        end
        S_WAIT_IDLE: begin
          if (!fl_busy) begin
            state_q <= S_LAUNCH;
          end else if (tmr_exp) begin
            status_q <= RSP_BUSY;
            state_q  <= S_RESP;
          end
        end
        S_LAUNCH: state_q <= S_POLL;
        S_POLL: begin
          if (fl_done) rdbuf_q <= fl_rdata;
          if (sts_done && !sts_err) begin
            status_q <= RSP_OK;
            if (!wr_q)
              rdata_q <= two_q ? rdbuf_q
                               : {{(DATA_W-BYTE_W){1'b0}}, rdbuf_q[BYTE_W-1:0]};
            state_q <= S_RESP;
          end else if (sts_err && (sts_done || tmr_exp)) begin
            if (retry_q == RLAST) begin
              status_q <= RSP_RETRY_OUT;
              state_q  <= S_RESP;
            end else begin
              retry_q <= retry_q + 1'b1;
              state_q <= S_PREP;
            end
          end else if (tmr_exp) begin
            status_q <= RSP_TIMEOUT;
            state_q  <= S_RESP;
          end
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == S_IDLE);
  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_status = status_q;
  assign rsp_rdata  = rdata_q;
  assign fl_go      = (state_q == S_LAUNCH);
  assign fl_type    = wr_q ? CYC_WRITE : CYC_READ;
  assign fl_bcount  = two_q;
  assign fl_addr    = addr_q;
  assign fl_wdata   = wdata_q;
endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [2:0]        rsp_status,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              fl_go,
  input logic              fl_busy,
  input logic              fl_desc_valid,
  input logic [1:0]        fl_type
);
  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_rdata));

  // R1
  chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R11
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_go |=> !fl_go);

  // R11
  go_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_go |-> !fl_busy);

  // R4
  go_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_go |-> (fl_type == 2'd0 || fl_type == 2'd2));

  // R5
  go_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_go |-> fl_desc_valid);

  // R2
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status <= 3'd5);

  // R9
  rdata_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != 3'd0 |-> rsp_rdata == '0);
endmodule

bind flash_cycle_seq flash_seq_checker #(.DATA_W(DATA_W)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
  .fl_go(fl_go), .fl_busy(fl_busy), .fl_desc_valid(fl_desc_valid), .fl_type(fl_type)
);

// File: tb/flash_cycle_seq_test.sv
`timescale 1ns/1ps
module flash_cycle_seq_test;
  localparam logic [23:0] TB_BASE = 24'hFF8000;
  localparam int TB_RETRY = 10;
  localparam int FOREVER_HOLD = 1000000;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0, rsp_ready = 0;
  logic [31:0] req_index = 0;
  logic [1:0]  req_size = 0;
  logic [15:0] req_wdata = 0;
  logic        req_ready, rsp_valid, fl_go, fl_bcount;
  logic [2:0]  rsp_status;
  logic [15:0] rsp_rdata, fl_wdata;
  logic [1:0]  fl_type;
  logic [23:0] fl_addr;
  logic        fl_busy, fl_done = 0, fl_err = 0, fl_desc_valid = 1;
  logic [15:0] fl_rdata = 0;

  int checks = 0, failures = 0;
  int cyc = 0, busy_until = 0;
  int go_cnt = 0, txn_base = 0, att_q = 0;
  int lat = 2, errn = 0, eng_left = 0;
  bit never = 0, eng_act = 0;
  logic [23:0] cap_addr = 0;
  logic [1:0]  cap_type = 0;
  logic        cap_bcount = 0;
  logic [15:0] cap_wdata = 0;

  flash_cycle_seq #(.BASE(TB_BASE), .CYC_PER_US(1), .TIMEOUT_US(16), .MAX_RETRY(TB_RETRY)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_index(req_index), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .fl_go(fl_go), .fl_type(fl_type), .fl_bcount(fl_bcount), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_busy(fl_busy), .fl_done(fl_done), .fl_err(fl_err), .fl_rdata(fl_rdata),
    .fl_desc_valid(fl_desc_valid)
  );

  assign fl_busy = eng_act | (cyc < busy_until);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    fl_done <= 0;
    fl_err  <= 0;
    if (fl_go) begin
      att_q <= go_cnt - txn_base;
      go_cnt <= go_cnt + 1;
      eng_act <= 1;
      eng_left <= lat;
      cap_addr <= fl_addr; cap_type <= fl_type; cap_bcount <= fl_bcount; cap_wdata <= fl_wdata;
    end else if (eng_act) begin
      if (eng_left == 0) begin
        eng_act <= 0;
        fl_done <= !never;
        fl_err  <= !never && (att_q < errn);
      end else eng_left <= eng_left - 1;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_status(input logic [1:0] sz, input logic [31:0] idx, input bit desc,
                                    input int hold, input bit nv, input int en);
    if (!(sz == 1 || sz == 2) || idx > 32'h00FFFFFF) return 1;
    if (!desc) return 5;
    if (hold >= FOREVER_HOLD) return 2;
    if (nv) return 3;
    if (en > TB_RETRY) return 4;
    return 0;
  endfunction

  function automatic int exp_gos(input int st, input int en);
    case (st)
      0: return en + 1;
      3: return 1;
      4: return TB_RETRY + 1;
      default: return 0;
    endcase
  endfunction

  task automatic txn(input bit wr, input logic [31:0] idx, input logic [1:0] sz, input logic [15:0] wd,
                     input bit desc, input int hold, input int l, input bit nv, input int en,
                     input logic [15:0] rd, input int stall);
    int st, gos, wait_n;
    logic [2:0] s0; logic [15:0] d0;
    logic [15:0] exp_rd, exp_wd;
    @(negedge clk);
    lat = l; never = nv; errn = en; fl_rdata = rd; fl_desc_valid = desc;
    txn_base = go_cnt; busy_until = cyc + hold;
    req_valid = 1; req_write = wr; req_index = idx; req_size = sz; req_wdata = wd;
    wait_n = 0;
    while (!req_ready && wait_n < 100) begin @(negedge clk); wait_n++; end
    @(negedge clk);
    req_valid = 0;
    check("R1 ready low in flight", req_ready, 0);
    wait_n = 0;
    while (!rsp_valid && wait_n < 2000) begin @(negedge clk); wait_n++; end
    s0 = rsp_status; d0 = rsp_rdata;
    for (int k = 0; k < stall; k++) @(negedge clk);
    check("R1 response held", {rsp_valid, rsp_status, rsp_rdata}, {1'b1, s0, d0});
    st  = exp_status(sz, idx, desc, hold, nv, en);
    gos = exp_gos(st, en);
    case (st)
      1: check("R2 status", rsp_status, st);
      2: check("R6 status", rsp_status, st);
      3: check("R7 timeout status", rsp_status, st);
      4: check("R8 status", rsp_status, st);
      5: check("R5 status", rsp_status, st);
      default: check("R7 ok status", rsp_status, st);
    endcase
    check("R8 go count", go_cnt - txn_base, gos);
    exp_rd = (st == 0 && !wr) ? ((sz == 2) ? rd : {8'h00, rd[7:0]}) : 16'h0;
    check("R9 rdata", rsp_rdata, exp_rd);
    if (gos > 0) begin
      check("R3 addr", cap_addr, (idx[23:0] + TB_BASE) & 24'hFFFFFF);
      check("R4 type", cap_type, wr ? 2 : 0);
      check("R4 bcount", cap_bcount, sz - 1);
      exp_wd = (sz == 2) ? wd : {8'h00, wd[7:0]};
      if (wr) check("R10 wdata", cap_wdata, exp_wd);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check("R1 ready after accept", req_ready, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset ready", req_ready, 1);
    check("R1 reset rsp_valid", rsp_valid, 0);
    check("R11 reset go", fl_go, 0);
    rst_n = 1;
    // directed corners
    txn(0, 32'h000100, 2'd1, 16'h0, 1, 0, 2, 0, 0, 16'hBEEF, 0);        // R9 size1 read
    txn(0, 32'h000102, 2'd2, 16'h0, 1, 0, 3, 0, 0, 16'hA55A, 2);        // R9 size2 read
    txn(1, 32'hFFFFFF, 2'd1, 16'h1234, 1, 0, 1, 0, 0, 16'h0, 0);        // R3 wrap, R10
    txn(1, 32'h000010, 2'd2, 16'hC0DE, 1, 3, 2, 0, 0, 16'h0, 0);        // R6 wait then go
    txn(0, 32'h01000000, 2'd1, 16'h0, 1, 0, 2, 0, 0, 16'h0, 0);         // R2 index
    txn(0, 32'h000000, 2'd0, 16'h0, 1, 0, 2, 0, 0, 16'h0, 0);           // R2 size 0
    txn(0, 32'h000000, 2'd3, 16'h0, 1, 0, 2, 0, 0, 16'h0, 0);           // R2 size 3
    txn(0, 32'h000040, 2'd1, 16'h0, 0, 0, 2, 0, 0, 16'h0, 0);           // R5
    txn(0, 32'h000040, 2'd1, 16'h0, 1, FOREVER_HOLD, 2, 0, 0, 16'h0, 0);// R6 busy out
    txn(0, 32'h000044, 2'd2, 16'h0, 1, 0, 2, 1, 0, 16'h0, 0);           // R7 timeout
    txn(0, 32'h000048, 2'd2, 16'h0, 1, 0, 1, 0, TB_RETRY, 16'h7788, 0); // R8 last try ok
    txn(1, 32'h00004C, 2'd2, 16'h5555, 1, 0, 1, 0, TB_RETRY + 1, 16'h0, 1); // R8 exhausted
    // random mix
    for (int n = 0; n < 250; n++) begin
      bit wr, desc, nv; logic [31:0] idx; logic [1:0] sz; int hold, en, r;
      wr = $urandom % 2;
      r = $urandom % 10;
      sz = (r == 0) ? 2'd0 : (r == 1) ? 2'd3 : 2'(1 + ($urandom % 2));
      idx = ($urandom % 10 == 0) ? $urandom : ($urandom & 32'h00FFFFFF);
      desc = ($urandom % 12) != 0;
      hold = ($urandom % 8 == 0) ? FOREVER_HOLD : int'($urandom % 5);
      nv = ($urandom % 10) == 0;
      en = ($urandom % 6 == 0) ? TB_RETRY + 1 : int'($urandom % 3);
      txn(wr, idx, sz, 16'($urandom), desc, hold, 1 + int'($urandom % 5), nv, en,
          16'($urandom), int'($urandom % 4));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule